// File: doc/BRIEF.md
# Two-Write Bus Loader for a 10-bit Converter Code

This block is the digital front end of a 10-bit digital-to-analog converter attached to an 8-bit processor bus. Software sends a code as two byte stores to a pair of consecutive addresses inside a small decoded window. Address bit 0 of each store does two jobs. It picks the byte being written, and it marks the second store as the trigger that moves the complete code into the holding register. The converter input therefore steps from one full code to the next and never shows a half-updated value.

The code is left justified over the two bytes. The upper byte gives code bits 9..2. Bits 7..6 of the lower byte give code bits 1..0. Software may store the upper byte first or the lower byte first, and a parameter sets which order the block expects.

A second load path takes both bytes in parallel, as two output ports would present them. An active-low transfer control drives this path. The bus address decode plays no part in it. While the control is low the output follows the port bytes. When the control returns high, the output keeps the last code it saw.

Top module: `bus_dac_front`

## Requirements
- R1: After reset the first-byte latch and the holding register are zero, and with `xfer_ni` high `code_o` reads 0.
- R2: A write whose address bits above `DEC_LSB` do not match `BASE_ADDR` changes neither `code_o` nor the first-byte latch.
- R3: A decoded write with address bit 0 = 1 (odd) stores `data_i` in the first-byte latch and leaves `code_o` unchanged.
- R4: A decoded write with address bit 0 = 0 (even) transfers the complete 10-bit code in one step. The code is built from the first-byte latch and the current `data_i`, and it is visible on `code_o` from the clock edge that takes the write onward.
- R5: The code is left justified. The high byte maps to `code_o[9:2]`, bits 7..6 of the low byte map to `code_o[1:0]`, and bits 5..0 of the low byte have no effect.
- R6: With `HI_FIRST`=1 the odd write carries the high byte and the even write carries the low byte. With `HI_FIRST`=0 the roles are swapped.
- R7: An even write with no odd write before it still transfers, and it uses whatever value the first-byte latch currently holds.
- R8: With `wr_i` low, a matching address and data have no effect.
- R9: While `xfer_ni` is low, `code_o` equals `{port_hi_i, port_lo_i[7:6]}` in the same cycle.
- R10: After `xfer_ni` rises, `code_o` holds the port code that was sampled at the last clock edge while `xfer_ni` was low. Later changes on the ports are ignored.
- R11: If a parallel transfer and an even bus write occur in the same cycle, the parallel code is loaded and the bus code is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per store |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Bus write data |
| port_hi_i | input | 8 | Parallel path, high byte |
| port_lo_i | input | 8 | Parallel path, low byte (bits 7..6 used) |
| xfer_ni | input | 1 | Parallel transfer control, active low |
| code_o | output | 10 | Code to the converter |

## Verification
A corrupted first-byte latch stays hidden until the next even write. At that point it shows up as wrong bits in one fixed part of `code_o`: bits 9..2 when the high byte goes first, and bits 1..0 otherwise. A decode or strobe error is different. It appears as a change in `code_o` one clock after an odd write or an out-of-window write, which is exactly where the bench samples. Errors on the parallel path appear within the same cycle while `xfer_ni` is low, or one cycle after it rises, as a held code that differs from the last port value.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned LO_W   = CODE_W - BYTE_W;

  function automatic logic [CODE_W-1:0] pack_code(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo[BYTE_W-1 -: LO_W]};
  endfunction
endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEC_LSB   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              odd_we_o,
  output logic              even_we_o
);
  logic hit;
  assign hit       = wr_i && (addr_i[ADDR_W-1:DEC_LSB] == BASE_ADDR[ADDR_W-1:DEC_LSB]);
  assign odd_we_o  = hit &&  addr_i[0];
  assign even_we_o = hit && !addr_i[0];
endmodule

// File: rtl/dac_byte_stage.sv
module dac_byte_stage
  import dac_front_pkg::*;
#(
  parameter bit HI_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              odd_we_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CODE_W-1:0] bus_code_o
);
  logic [BYTE_W-1:0] first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       first_q <= '0;
    else if (odd_we_i) first_q <= data_i;
  end

  // second byte goes straight to the holding register on the even write
  generate
    if (HI_FIRST) begin : g_hi_first
      assign bus_code_o = pack_code(first_q, data_i);
    end else begin : g_lo_first
      assign bus_code_o = pack_code(data_i, first_q);
    end
  endgenerate

  // R3
  first_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_we_i |=> first_q == $past(data_i));
  // R7
  first_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odd_we_i |=> $stable(first_q));
endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
  import dac_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_bus_i,
  input  logic [CODE_W-1:0] bus_code_i,
  input  logic              load_par_i,
  input  logic [CODE_W-1:0] par_code_i,
  output logic [CODE_W-1:0] hold_o
);
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (load_par_i) hold_q <= par_code_i;
    else if (load_bus_i) hold_q <= bus_code_i;
  end
  assign hold_o = hold_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_bus_i && !load_par_i |=> $stable(hold_q));
  // R4
  bus_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_bus_i && !load_par_i |=> hold_q == $past(bus_code_i));
  // R11
  par_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_par_i |=> hold_q == $past(par_code_i));
endmodule

// File: rtl/bus_dac_front.sv
module bus_dac_front
  import dac_front_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DEC_LSB   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
  parameter bit                HI_FIRST  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BYTE_W-1:0] port_hi_i,
  input  logic [BYTE_W-1:0] port_lo_i,
  input  logic              xfer_ni,
  output logic [CODE_W-1:0] code_o
);
  logic              odd_we, even_we, par_active;
  logic [CODE_W-1:0] bus_code, par_code, hold;

  dac_addr_decode #(.ADDR_W(ADDR_W), .DEC_LSB(DEC_LSB), .BASE_ADDR(BASE_ADDR)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .odd_we_o(odd_we), .even_we_o(even_we));

  dac_byte_stage #(.HI_FIRST(HI_FIRST)) u_bytes (
    .clk_i(clk_i), .rst_ni(rst_ni), .odd_we_i(odd_we), .data_i(data_i),
    .bus_code_o(bus_code));

  assign par_active = !xfer_ni;
  assign par_code   = pack_code(port_hi_i, port_lo_i);

  dac_hold_reg u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_bus_i(even_we), .bus_code_i(bus_code),
    .load_par_i(par_active), .par_code_i(par_code),
    .hold_o(hold));

  // transparent while parallel control is low
  assign code_o = par_active ? par_code : hold;

  // R9
  transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_ni |-> code_o == {port_hi_i, port_lo_i[7:6]});
  // R10
  latch_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_ni) |-> code_o == $past({port_hi_i, port_lo_i[7:6]}));
endmodule

// File: tb/bus_dac_front_tb_top.sv
module bus_dac_front_tb_top;
  logic        clk = 0, rst_ni = 0, wr = 0, xfer_n = 1;
  logic [15:0] addr = 0;
  logic [7:0]  data = 0, phi = 0, plo = 0;
  logic [9:0]  code_a, code_b;
  logic [7:0]  m_first = 0;
  logic [9:0]  exp_a = 0, exp_b = 0;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [15:0] ODD = 16'h4001, EVEN = 16'h4002;

  always #10 clk = ~clk;

  bus_dac_front #(.HI_FIRST(1'b1)) dut_i (.clk_i(clk), .rst_ni(rst_ni), .wr_i(wr),
    .addr_i(addr), .data_i(data), .port_hi_i(phi), .port_lo_i(plo), .xfer_ni(xfer_n),
    .code_o(code_a));
  bus_dac_front #(.HI_FIRST(1'b0)) dut_b (.clk_i(clk), .rst_ni(rst_ni), .wr_i(wr),
    .addr_i(addr), .data_i(data), .port_hi_i(phi), .port_lo_i(plo), .xfer_ni(xfer_n),
    .code_o(code_b));

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    check({req, " hi-first"}, code_a, exp_a);
    check({req, " lo-first"}, code_b, exp_b);
  endtask

  // one bus cycle, with model update; results sampled at the following negedge
  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic strobe);
    @(negedge clk);
    wr = strobe; addr = a; data = d;
    @(negedge clk);
    wr = 0;
    if (strobe && a[15:2] == 14'h1000) begin
      if (a[0]) m_first = d;
      else if (xfer_n) begin
        exp_a = {m_first, d[7:6]};
        exp_b = {d, m_first[7:6]};
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_both("R1");
    rst_ni = 1;
    @(negedge clk);
    check_both("R1");

    // R7: even write before any odd write uses reset-value first latch
    bus_wr(EVEN, 8'hC0, 1); check_both("R7");

    // R3/R4/R5/R6: sweep every 10-bit code in both byte orders
    for (int c = 0; c < 1024; c++) begin
      logic [7:0] hi, lo;
      hi = c[9:2];
      lo = {c[1:0], 6'(c * 7)};   // junk in low bits, R5
      bus_wr(ODD, hi, 1);  check_both("R3");
      bus_wr(EVEN, lo, 1); check_both("R4");
      check("R5 R6 code", code_a, c[9:0]);
    end

    // R2: out-of-window odd and even
    bus_wr(16'h4005, 8'h11, 1); check_both("R2");
    bus_wr(16'h4006, 8'h22, 1); check_both("R2");
    bus_wr(16'h0002, 8'h33, 1); check_both("R2");
    bus_wr(EVEN, 8'h80, 1);     check_both("R2 latch untouched");

    // R8: no strobe
    bus_wr(ODD, 8'h5A, 0);  check_both("R8");
    bus_wr(EVEN, 8'hFF, 0); check_both("R8");
    bus_wr(EVEN, 8'h40, 1); check_both("R8 latch untouched");

    // R7: repeat even write reuses stale first latch
    bus_wr(ODD, 8'hA5, 1);
    bus_wr(EVEN, 8'h00, 1); check_both("R7");
    bus_wr(EVEN, 8'hC0, 1); check_both("R7");

    // R9/R10: parallel path sweep
    for (int c = 0; c < 1024; c += 3) begin
      logic [9:0] nxt;
      nxt = 10'(c * 37 + 5);
      @(negedge clk);
      xfer_n = 0; phi = c[9:2]; plo = {c[1:0], 6'h2A};
      #1 check("R9", code_a, c[9:0]);
      check("R9", code_b, c[9:0]);
      @(negedge clk);
      xfer_n = 1; phi = nxt[9:2]; plo = {nxt[1:0], 6'h15};
      #1 check("R10", code_a, c[9:0]);
      check("R10", code_b, c[9:0]);
      exp_a = c[9:0]; exp_b = c[9:0];
      @(negedge clk);
      check_both("R10 hold");
    end

    // R11: parallel and even write together
    bus_wr(ODD, 8'h12, 1);
    @(negedge clk);
    xfer_n = 0; phi = 8'h3C; plo = 8'h80; wr = 1; addr = EVEN; data = 8'hFF;
    @(negedge clk);
    wr = 0; xfer_n = 1; phi = 0; plo = 0;
    exp_a = {8'h3C, 2'b10}; exp_b = exp_a;
    #1 check_both("R11");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule